// File: doc/BRIEF.md
# Token-Passing Serial Readout Controller

This block sits in each front-end chip of a daisy chain that shares one serial data line. During the readout phase a single-cycle token travels along the chain. A chip that receives the token while it is idle and the readout phase is enabled drives the shared line and sends a header with its identifier and its number of stored events. It then sends every stored event word, reading them one by one from a local RAM through a read port with one cycle of latency, and finally passes the token to its neighbour. A chip holding no events sends nothing and forwards the token at once. Time on the bus therefore grows with the number of hits and not with the number of chips.

Each event word holds, from the most significant end down, coarse time, fine time, charge, a one-bit shaper-gain flag and a one-bit trigger-status flag. The controller sends the whole word without decoding it. After the token leaves, a completion flag stays set until the next acquisition starts. Until then the chip ignores any further token.

The state machine has five states. S_IDLE waits for the token. S_HDR sends the header. S_DATA sends the event words. S_PASS drives the token out. S_DONE holds the completion flag. The transitions are: accept_full (S_IDLE to S_HDR: token, readout enabled, count not zero), accept_empty (S_IDLE to S_PASS: token, readout enabled, count zero), hdr_end (S_HDR to S_DATA), next_event (S_DATA to S_DATA), data_end (S_DATA to S_PASS), handoff (S_PASS to S_DONE) and rearm (S_DONE to S_IDLE on acquisition start).

Top module: `rdo_token_ctrl`

## Requirements
- R1: After reset, tx_en, ser_dout, token_out and readout_done are all 0.
- R2: A token pulse is ignored, with no transmission and no token_out, unless the controller is idle and daq_en is 1. This includes a token that arrives after readout_done is set.
- R3: The first bits sent are the header, most significant bit first. It is the 8-bit chip_id followed by the event count in CNT_W = clog2(DEPTH+1) bits, and it starts in the cycle after the token is sampled.
- R4: The header is followed with no gap by the event words. These are read from addresses 0 up to count-1, and each word is EVT_W bits sent most significant bit first: coarse time, fine time, charge, gain flag, then trigger flag in bit 0.
- R5: tx_en is 1 in exactly the cycles that carry header or event bits, and ser_dout is 0 whenever tx_en is 0.
- R6: token_out is a one-cycle pulse in the cycle right after the last data bit, so it comes HDR_W + count*EVT_W + 1 cycles after the token_in cycle.
- R7: With an event count of zero, token_out pulses in the cycle after token_in and nothing is sent.
- R8: readout_done rises together with token_out and stays at 1 until acq_start is sampled. It is 0 from the next cycle on.
- R9: An event count above DEPTH is saturated to DEPTH, both in the header and in the number of words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| daq_en | input | 1 | Readout phase active |
| acq_start | input | 1 | Start of acquisition; clears readout_done |
| token_in | input | 1 | Token pulse from previous chip |
| chip_id | input | 8 | Identifier of this chip |
| evt_count | input | CNT_W | Number of stored events |
| ram_addr | output | ADDR_W | Event RAM read address |
| ram_rdata | input | EVT_W | Event RAM read data, one cycle after address |
| token_out | output | 1 | Token pulse to next chip |
| ser_dout | output | 1 | Serial data onto shared line |
| tx_en | output | 1 | This chip drives the shared line |
| readout_done | output | 1 | Token has left this chip |

## Verification
The bench builds the block with DEPTH = 4 and the default field widths. This makes CNT_W 3 bits and each event word 38 bits. With that depth, a completely full RAM and a count above the depth (7, saturated to 4) both fit into short runs. The event words place distinct patterns in every field, so a bit-order or address-order mistake shows up in the scoreboard. Runs with zero, one, two and four events, with different chip IDs, cover the empty handoff and both the single-word and the multi-word case of the data state.

// File: rtl/rdo_pkg.sv
`timescale 1ns/1ps
package rdo_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_DATA,
        S_PASS,
        S_DONE
    } rdo_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rdo_shifter.sv
`timescale 1ns/1ps
module rdo_shifter #(
    parameter int SH_W  = 38,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SH_W-1:0]  load_val,
    input  logic [LEN_W-1:0] load_len,
    input  logic             shift,
    output logic             bit_out,
    output logic             last
);

    logic [SH_W-1:0]  sh_q;
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            rem_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            rem_q <= load_len;
        end else if (shift) begin
            sh_q  <= sh_q << 1;
            rem_q <= rem_q - 1'b1;
        end
    end

    assign bit_out = sh_q[SH_W-1];
    assign last    = (rem_q == '0);

    // R4: a word is never shifted past its final bit
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |-> !last);

endmodule

// File: rtl/rdo_evt_ptr.sv
`timescale 1ns/1ps
module rdo_evt_ptr #(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);

    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            count_q <= '0;
        end else if (start) begin
            idx_q   <= '0;
            count_q <= start_count;
        end else if (advance) begin
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign addr   = idx_q[ADDR_W-1:0];
    assign at_end = (idx_q == count_q);

    // R9: the latched count never exceeds the storage depth
    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R4: reads never run beyond the latched count
    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= count_q);

endmodule

// File: rtl/rdo_token_ctrl.sv
`timescale 1ns/1ps
module rdo_token_ctrl
    import rdo_pkg::*;
#(
    parameter int ID_W     = 8,
    parameter int DEPTH    = 16,
    parameter int COARSE_W = 12,
    parameter int FINE_W   = 12,
    parameter int CHARGE_W = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  daq_en,
    input  logic                                  acq_start,
    input  logic                                  token_in,
    input  logic [ID_W-1:0]                       chip_id,
    input  logic [$clog2(DEPTH+1)-1:0]            evt_count,
    output logic [$clog2(DEPTH)-1:0]              ram_addr,
    input  logic [COARSE_W+FINE_W+CHARGE_W+1:0]   ram_rdata,
    output logic                                  token_out,
    output logic                                  ser_dout,
    output logic                                  tx_en,
    output logic                                  readout_done
);

    localparam int EVT_W  = COARSE_W + FINE_W + CHARGE_W + 2;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int HDR_W  = ID_W + CNT_W;
    localparam int SH_W   = max_int(HDR_W, EVT_W);
    localparam int LEN_W  = $clog2(SH_W);

    rdo_state_e state_q, state_d;

    logic             accept;
    logic [CNT_W-1:0] cnt_sat;
    logic             sh_last;
    logic             sh_bit;
    logic             sh_load;
    logic             sh_shift;
    logic [SH_W-1:0]  sh_val;
    logic [LEN_W-1:0] sh_len;
    logic             ptr_end;
    logic             ptr_adv;
    logic             word_end;

    assign accept   = (state_q == S_IDLE) && token_in && daq_en;
    assign cnt_sat  = (evt_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : evt_count;
    assign word_end = ((state_q == S_HDR) || (state_q == S_DATA)) && sh_last;
    assign ptr_adv  = word_end && ((state_q == S_HDR) || !ptr_end);
    assign sh_load  = (accept && (cnt_sat != '0)) || ptr_adv;
    assign sh_shift = ((state_q == S_HDR) || (state_q == S_DATA)) && !sh_last;

    always_comb begin
        if (state_q == S_IDLE) begin
            sh_val = SH_W'({chip_id, cnt_sat}) << (SH_W - HDR_W);
            sh_len = LEN_W'(HDR_W - 1);
        end else begin
            sh_val = SH_W'(ram_rdata) << (SH_W - EVT_W);
            sh_len = LEN_W'(EVT_W - 1);
        end
    end

    rdo_shifter #(
        .SH_W  (SH_W),
        .LEN_W (LEN_W)
    ) i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .load_len (sh_len),
        .shift    (sh_shift),
        .bit_out  (sh_bit),
        .last     (sh_last)
    );

    rdo_evt_ptr #(
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) i_evt_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_count (cnt_sat),
        .advance     (ptr_adv),
        .addr        (ram_addr),
        .at_end      (ptr_end)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = (cnt_sat == '0) ? S_PASS : S_HDR;
            S_HDR:  if (sh_last) state_d = S_DATA;
            S_DATA: if (sh_last && ptr_end) state_d = S_PASS;
            S_PASS: state_d = S_DONE;
            S_DONE: if (acq_start) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        tx_en        = 1'b0;
        token_out    = 1'b0;
        readout_done = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_HDR,
            S_DATA: tx_en = 1'b1;
            S_PASS: begin
                token_out    = 1'b1;
                readout_done = 1'b1;
            end
            S_DONE: readout_done = 1'b1;
            default: ;
        endcase
        ser_dout = tx_en & sh_bit;
    end

    p_tx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !ser_dout);

    p_tok_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !token_out);

    p_tok_after_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> token_out);

    p_tx_needs_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(token_in && daq_en));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (readout_done && !acq_start && !token_out) |=> readout_done);

    p_no_tx_when_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        readout_done |-> !tx_en);

endmodule

// File: tb/test_rdo_token_ctrl.sv
`timescale 1ns/1ps
module test_rdo_token_ctrl;

    localparam int ID_W   = 8;
    localparam int DEPTH  = 4;
    localparam int CW     = 12;
    localparam int EVT_W  = 3 * CW + 2;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int HDR_W  = ID_W + CNT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic daq_en = 1'b0;
    logic acq_start = 1'b0;
    logic token_in = 1'b0;
    logic [ID_W-1:0] chip_id = '0;
    logic [CNT_W-1:0] evt_count = '0;
    logic [ADDR_W-1:0] ram_addr;
    logic [EVT_W-1:0] ram_rdata;
    logic token_out, ser_dout, tx_en, readout_done;

    logic [EVT_W-1:0] mem [DEPTH];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    bit    exp_bits [$];
    string exp_tags [$];

    always #2 clk = ~clk;

    always @(posedge clk) ram_rdata <= mem[ram_addr];

    rdo_token_ctrl #(
        .ID_W(ID_W), .DEPTH(DEPTH), .COARSE_W(CW), .FINE_W(CW), .CHARGE_W(CW)
    ) i_rdo_token_ctrl (
        .clk(clk), .rst_n(rst_n), .daq_en(daq_en), .acq_start(acq_start),
        .token_in(token_in), .chip_id(chip_id), .evt_count(evt_count),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata), .token_out(token_out),
        .ser_dout(ser_dout), .tx_en(tx_en), .readout_done(readout_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compares every transmitted bit with the scoreboard
    always @(negedge clk) begin
        if (rst_n && tx_en) begin
            if (exp_bits.size() == 0) begin
                check(1'b0, "R5 unexpected tx_en", 1, 0);
            end else begin
                bit    eb;
                string et;
                eb = exp_bits.pop_front();
                et = exp_tags.pop_front();
                check(ser_dout == eb, et, int'(ser_dout), int'(eb));
            end
        end
    end

    function automatic logic [EVT_W-1:0] make_evt(input int chip, input int i);
        logic [CW-1:0] coarse, fine, charge;
        coarse = CW'(12'hA00 + chip * 16 + i);
        fine   = CW'(12'h05C ^ (chip << 4) ^ i);
        charge = CW'(12'hF0F - i * 3);
        return {coarse, fine, charge, 1'(i), 1'(~i)};
    endfunction

    // driver: loads RAM, pushes expected bits, sends token, measures handoff
    task automatic run_chip(input int id, input int n_req);
        int n_eff;
        int exp_lat;
        int lat;
        logic [HDR_W-1:0] hdr;
        n_eff = (n_req > DEPTH) ? DEPTH : n_req;
        hdr = {ID_W'(id), CNT_W'(n_eff)};
        for (int i = 0; i < DEPTH; i++) mem[i] = make_evt(id, i);
        if (n_eff > 0) begin
            for (int b = HDR_W - 1; b >= 0; b--) begin
                exp_bits.push_back(hdr[b]);
                exp_tags.push_back((n_req > DEPTH) ? "R9 header count" : "R3 header bit");
            end
            for (int i = 0; i < n_eff; i++) begin
                logic [EVT_W-1:0] w;
                w = make_evt(id, i);
                for (int b = EVT_W - 1; b >= 0; b--) begin
                    exp_bits.push_back(w[b]);
                    exp_tags.push_back("R4 event bit");
                end
            end
        end
        exp_lat = (n_eff > 0) ? HDR_W + n_eff * EVT_W + 1 : 1;
        @(negedge clk);
        chip_id   = ID_W'(id);
        evt_count = CNT_W'(n_req);
        token_in  = 1'b1;
        @(negedge clk);
        token_in  = 1'b0;
        lat = 0;
        for (int k = 1; k < 2000; k++) begin
            if (token_out) begin
                lat = k;
                break;
            end
            @(negedge clk);
        end
        if (n_eff == 0) check(lat == exp_lat, "R7 empty handoff latency", lat, exp_lat);
        else            check(lat == exp_lat, "R6 token_out latency", lat, exp_lat);
        check(readout_done == 1'b1, "R8 done with token_out", int'(readout_done), 1);
        check(exp_bits.size() == 0, "R4 all bits sent", exp_bits.size(), 0);
        check(tx_en == 1'b0, "R5 tx_en low at handoff", int'(tx_en), 0);
        @(negedge clk);
        check(token_out == 1'b0, "R6 single-cycle token", int'(token_out), 0);
        check(readout_done == 1'b1, "R8 done held", int'(readout_done), 1);
    endtask

    task automatic token_ignored(input string tag);
        int seen;
        seen = 0;
        @(negedge clk);
        evt_count = CNT_W'(2);
        token_in  = 1'b1;
        @(negedge clk);
        token_in  = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (tx_en || token_out || ser_dout) seen++;
            @(negedge clk);
        end
        check(seen == 0, tag, seen, 0);
    endtask

    task automatic rearm();
        @(negedge clk);
        acq_start = 1'b1;
        @(negedge clk);
        acq_start = 1'b0;
        check(readout_done == 1'b0, "R8 cleared by acq_start", int'(readout_done), 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(tx_en == 1'b0, "R1 tx_en reset", int'(tx_en), 0);
        check(ser_dout == 1'b0, "R1 ser_dout reset", int'(ser_dout), 0);
        check(token_out == 1'b0, "R1 token_out reset", int'(token_out), 0);
        check(readout_done == 1'b0, "R1 done reset", int'(readout_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        token_ignored("R2 token outside readout phase");
        check(readout_done == 1'b0, "R2 done untouched", int'(readout_done), 0);

        daq_en = 1'b1;
        run_chip(8'h5A, 2);
        token_ignored("R2 token while done");
        rearm();

        run_chip(8'h13, 0);
        rearm();

        run_chip(8'hC3, DEPTH);
        rearm();

        run_chip(8'h7E, 7);
        rearm();

        run_chip(8'h01, 1);
        repeat (3) @(negedge clk);
        check(readout_done == 1'b1, "R8 done stays set", int'(readout_done), 1);
        rearm();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule